// File: doc/BRIEF.md
# Keyed Configuration Port Decoder

This block gives a host a way into a chip's configuration space through two byte addresses. The index port is at address bit 0 = 0 and the data port at address bit 0 = 1. The index port selects a configuration register, and the data port reads or writes the register that the index selects.

The port stays locked after reset. It opens only when the unlock key 0x87 goes to the index port on two consecutive index writes. It closes again when the lock byte 0xAA goes to the index port. While the port is open, the host can read the chip identification bytes and can choose a logical device through the device-select register. For the watchdog logical device, the host can set that device's enable bit and can reach its private registers. The block passes accesses to those private registers through to a child block.

The bus is synchronous. A write takes effect on the rising clock edge at which `wr` is high. Read data is combinational: it follows the current address, the index and the stored state.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the port is locked. A single index write of 0x87 leaves it locked, and a second consecutive index write of 0x87 opens it.
- R2: An index write of any value other than 0x87, made between the two key bytes, cancels the partial sequence. Two further 0x87 index writes are then needed to open the port.
- R3: While the port is open, an index write of 0xAA locks the port and leaves the index register unchanged.
- R4: While the port is locked, reads of the data port and of the index port return 0xFF, and writes to the data port change no register.
- R5: Reset clears the device-select register and the watchdog enable bit to 0.
- R6: While the port is open, index 0x20 reads DEV_ID[15:8], index 0x21 reads DEV_ID[7:0], index 0x22 reads DEV_REV, index 0x23 reads VENDOR_ID[15:8] and index 0x24 reads VENDOR_ID[7:0]. Data writes to these indices are ignored.
- R7: Index 0x07 is the device-select register. It is read/write and is driven on `ldn_sel`.
- R8: At index 0x30, bit 0 is the enable of the watchdog device (device number WDT_LDN) and drives `wdt_en`. Bits 7:1 read as 0. When a different device is selected, index 0x30 reads 0x00 and writes to it are ignored.
- R9: When the watchdog device is selected, data-port accesses to indices 0x31 to 0xFF go to the child block:
  - a write pulses `child_wr` with `child_idx` and `child_wdata`;
  - a read returns `child_rdata`;
  - when another device is selected, these indices read 0x00 and `child_wr` stays low.
- R10: While the port is open, a read of the index port returns the current index value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | 0 selects the index port, 1 selects the data port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| ldn_sel | output | 8 | Selected logical device number |
| wdt_en | output | 1 | Watchdog device enable |
| child_idx | output | 8 | Current index, presented to the child block |
| child_wdata | output | 8 | Write data to the child block |
| child_wr | output | 1 | Write pulse to a watchdog private register |
| child_rd | output | 1 | Read strobe to a watchdog private register |
| child_rdata | input | 8 | Read data from the child block |

## Verification
The bench overrides DEV_ID with 16'hB2C4 and DEV_REV with 8'h9E. With these values all five identification bytes differ from one another, so a swapped byte order or a wrong index decode gives a visibly wrong read. WDT_LDN keeps its default of 0x07, which is the same number as the device-select index. This puts within reach the case of switching between the watchdog device and another device (0x03), and of showing that the enable bit and the private registers are isolated from the other device. The bench models the child block as a byte array. Writes to private registers are then proven by reading them back through the data port.

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port #(
  parameter logic [15:0] DEV_ID    = 16'h0A51,
  parameter logic [15:0] VENDOR_ID = 16'h1934,
  parameter logic [7:0]  DEV_REV   = 8'h03,
  parameter logic [7:0]  KEY_OPEN  = 8'h87,
  parameter logic [7:0]  KEY_CLOSE = 8'hAA,
  parameter logic [7:0]  WDT_LDN   = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] ldn_sel,
  output logic       wdt_en,
  output logic [7:0] child_idx,
  output logic [7:0] child_wdata,
  output logic       child_wr,
  output logic       child_rd,
  input  logic [7:0] child_rdata
);

  localparam logic [7:0] IX_LDN   = 8'h07;
  localparam logic [7:0] IX_IDHI  = 8'h20;
  localparam logic [7:0] IX_IDLO  = 8'h21;
  localparam logic [7:0] IX_REV   = 8'h22;
  localparam logic [7:0] IX_VNHI  = 8'h23;
  localparam logic [7:0] IX_VNLO  = 8'h24;
  localparam logic [7:0] IX_EN    = 8'h30;
  localparam logic [7:0] LOCKED_RD = 8'hFF;

  typedef enum logic [1:0] {ST_LOCK, ST_HALF, ST_OPEN} key_st_t;

  key_st_t    st;
  logic [7:0] idx_q;
  logic [7:0] ldn_q;
  logic       en_q;

  logic idx_wr, dat_wr, is_open, wdt_sel, priv_ix;

  assign is_open = (st == ST_OPEN);
  assign idx_wr  = wr && !addr;
  assign dat_wr  = wr && addr && is_open;
  assign wdt_sel = (ldn_q == WDT_LDN);
  assign priv_ix = (idx_q > IX_EN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_LOCK;
    end else if (idx_wr) begin
      case (st)
        ST_LOCK: if (wdata == KEY_OPEN) st <= ST_HALF;
        ST_HALF: st <= (wdata == KEY_OPEN) ? ST_OPEN : ST_LOCK;
        ST_OPEN: if (wdata == KEY_CLOSE) st <= ST_LOCK;
        default: st <= ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (idx_wr && is_open && wdata != KEY_CLOSE) idx_q <= wdata;
      if (dat_wr && idx_q == IX_LDN) ldn_q <= wdata;
      if (dat_wr && idx_q == IX_EN && wdt_sel) en_q <= wdata[0];
    end
  end

  logic [7:0] cfg_rd;
  always_comb begin
    cfg_rd = 8'h00;
    case (idx_q)
      IX_LDN:  cfg_rd = ldn_q;
      IX_IDHI: cfg_rd = DEV_ID[15:8];
      IX_IDLO: cfg_rd = DEV_ID[7:0];
      IX_REV:  cfg_rd = DEV_REV;
      IX_VNHI: cfg_rd = VENDOR_ID[15:8];
      IX_VNLO: cfg_rd = VENDOR_ID[7:0];
      IX_EN:   cfg_rd = wdt_sel ? {7'b0, en_q} : 8'h00;
      default: cfg_rd = (priv_ix && wdt_sel) ? child_rdata : 8'h00;
    endcase
  end

  assign rdata       = !is_open ? LOCKED_RD : (addr ? cfg_rd : idx_q);
  assign ldn_sel     = ldn_q;
  assign wdt_en      = en_q;
  assign child_idx   = idx_q;
  assign child_wdata = wdata;
  assign child_wr    = dat_wr && wdt_sel && priv_ix;
  assign child_rd    = rd && addr && is_open && wdt_sel && priv_ix;

  // R1
  unlock_two_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOCK) |=> (st != ST_OPEN));

  // R2
  key_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HALF && idx_wr && wdata != KEY_OPEN) |=> (st == ST_LOCK));

  // R3
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_open && idx_wr && wdata == KEY_CLOSE) |=> (st == ST_LOCK) && $stable(idx_q));

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_open && wr && addr) |=> $stable(ldn_q) && $stable(en_q));

  // R8
  en_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(wr && addr && wdt_sel));

  // R9
  child_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    child_wr |-> (is_open && ldn_sel == WDT_LDN && child_idx > IX_EN));

endmodule

// File: tb/tb_keyed_cfg_port.sv
module tb_keyed_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic addr = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, ldn_sel, child_idx, child_wdata, child_rdata;
  logic wdt_en, child_wr, child_rd;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] cmem [0:255];

  always #5 clk = ~clk;

  keyed_cfg_port #(.DEV_ID(16'hB2C4), .DEV_REV(8'h9E)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .ldn_sel(ldn_sel), .wdt_en(wdt_en), .child_idx(child_idx),
    .child_wdata(child_wdata), .child_wr(child_wr), .child_rd(child_rd),
    .child_rdata(child_rdata));

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) cmem[i] <= 8'h00;
    end else if (child_wr) cmem[child_idx] <= child_wdata;
  end
  assign child_rdata = cmem[child_idx];

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #3;
    if (rd) chk(rdata, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic wr_port(input logic a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_port(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic unlock();
    wr_port(0, 8'h87); wr_port(0, 8'h87);
  endtask

  task automatic set_reg(input logic [7:0] ix, input logic [7:0] d);
    wr_port(0, ix); wr_port(1, d);
  endtask

  task automatic get_reg(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    wr_port(0, ix); rd_port(1, exp, tag);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ldn_sel, 8'h00, "R5 ldn reset");
    chk({7'b0, wdt_en}, 8'h00, "R5 enable reset");
    rd_port(1, 8'hFF, "R4 locked data read");
    rd_port(0, 8'hFF, "R4 locked index read");
    wr_port(0, 8'h87);
    rd_port(1, 8'hFF, "R1 one key byte");
    wr_port(0, 8'h11); wr_port(0, 8'h87);
    rd_port(1, 8'hFF, "R2 broken sequence");
    wr_port(0, 8'h87);
    rd_port(0, 8'h00, "R1 open after two keys");
    rd_port(0, 8'h00, "R10 index reads back");
    set_reg(8'h07, 8'h07);
    chk(ldn_sel, 8'h07, "R7 ldn port");
    get_reg(8'h07, 8'h07, "R7 ldn readback");
    wr_port(0, 8'h30);
    wr_port(0, 8'hAA);
    rd_port(0, 8'hFF, "R3 relocked index");
    rd_port(1, 8'hFF, "R3 relocked data");
    wr_port(1, 8'h01);
    chk({7'b0, wdt_en}, 8'h00, "R4 locked write ignored");
    unlock();
    rd_port(0, 8'h30, "R3 index kept over lock");
    rd_port(1, 8'h00, "R4 enable still clear");
    get_reg(8'h20, 8'hB2, "R6 id high");
    get_reg(8'h21, 8'hC4, "R6 id low");
    get_reg(8'h22, 8'h9E, "R6 revision");
    get_reg(8'h23, 8'h19, "R6 vendor high");
    get_reg(8'h24, 8'h34, "R6 vendor low");
    set_reg(8'h20, 8'h00);
    rd_port(1, 8'hB2, "R6 id read-only");
    set_reg(8'h30, 8'hFF);
    chk({7'b0, wdt_en}, 8'h01, "R8 enable set");
    rd_port(1, 8'h01, "R8 enable readback");
    set_reg(8'h07, 8'h03);
    get_reg(8'h30, 8'h00, "R8 other device reads 0");
    wr_port(1, 8'h00);
    chk({7'b0, wdt_en}, 8'h01, "R8 other device write ignored");
    set_reg(8'h41, 8'h99);
    rd_port(1, 8'h00, "R9 other device private reads 0");
    set_reg(8'h07, 8'h07);
    get_reg(8'h41, 8'h00, "R9 other device did not write child");
    set_reg(8'h41, 8'h3C);
    rd_port(1, 8'h3C, "R9 child write/read");
    set_reg(8'hFF, 8'hC3);
    rd_port(1, 8'hC3, "R9 top index");
    rd_port(0, 8'hFF, "R10 index value");
    get_reg(8'h41, 8'h3C, "R9 child kept");
    set_reg(8'h30, 8'h00);
    chk({7'b0, wdt_en}, 8'h00, "R8 enable clear");
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule